// File: doc/BRIEF.md
# Bulk Endpoint Packet Length Validator

This block tracks byte counts for one double-buffered bulk endpoint that a microprocessor fills and drains through programmed I/O. When the endpoint sends data to the host, the block counts the bytes that the processor writes into the buffer it owns. It hands that buffer to the USB side once the count reaches the maximum packet size. It can also hand it over earlier, at a short length that software has loaded beforehand. Software may also force the hand-over with a control bit. A transfer that is not a whole number of maximum-size packets therefore needs one length write before its final packet and nothing else.

When the endpoint receives data from the host, the same count register holds the byte count of the last acknowledged packet, and an interrupt tells software that the count is valid. The FIFO storage, the serial engine and the PHY are outside the block. It only produces the write strobes and lane enables for the buffer memory, plus the ready flag and length for the transmitter.

Registers are reached through an endpoint index. Index bit 0 selects the direction and the upper index bits select the endpoint number. The control endpoint, number 0, never matches.

Top module: `epbuf_len_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) or a bus reset (`usb_bus_rst` high for one cycle), the index reads 0 and both count registers read 0. The packet size reads the default of 64, no buffer is pending, `ep_irq` is 0, `dat_stall` is 0, and the buffer fill count is 0.
- R2: Register addresses are 0 = index, 1 = count, 2 = control, 3 = packet size. Index bits [3:1] must equal the endpoint number 2 for count, control and packet-size accesses to take effect. Index bit 0 = 1 selects the transmit side and 0 selects the receive side. With any other endpoint number, these accesses read 0 and writes are ignored.
- R3: With no short length loaded, a buffer is committed when its fill reaches the packet size. The next cycle shows `tx_valid` = 1 with `tx_len` equal to the packet size.
- R4: A count-register write on the transmit side loads a short length. A value from 1 to packet size minus 1 commits the buffer when the fill reaches that value.
- R5: Every commit returns the transmit count register to 0, so the next packet commits at the full packet size again.
- R6: Writing control bit 0 on the transmit side commits the current partially filled buffer with its present fill, which may be zero.
- R7: `dat_be` = 2'b11 is a word write and 2'b01 is a low-byte write. A word write that has room for only one more byte is accepted with `fifo_be` = 2'b01, meaning the low lane only, and commits the buffer.
- R8: Committed buffers are offered to the USB side in the order they were filled. The processor can fill the second buffer while the first is pending.
- R9: While both buffers are committed, `dat_stall` is 1. Data writes are then not accepted (`fifo_we` = 0) and not counted, and control bit 0 has no effect.
- R10: A `usb_out_ack` pulse loads the receive count register with `usb_out_len` and sets `ep_irq`. Writing control bit 1 on the receive side clears `ep_irq`. Control-register reads show the interrupt in bit 1.
- R11: Both count registers are readable and writable through the count address.
- R12: `usb_in_ack` while `tx_valid` is 1 frees the offered buffer. `tx_valid` then drops unless the other buffer is also committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| usb_bus_rst | input | 1 | Synchronous reset pulse from a USB bus reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| dat_wr | input | 1 | Transmit data write strobe |
| dat_be | input | 2 | Data write lanes: 11 word, 01 low byte |
| dat_stall | output | 1 | Processor-side buffer still committed; writes refused |
| fifo_we | output | 1 | Data write accepted into buffer memory |
| fifo_be | output | 2 | Lanes actually written |
| usb_in_ack | input | 1 | Host acknowledged the offered buffer |
| tx_valid | output | 1 | A committed buffer is offered |
| tx_len | output | 16 | Byte length of the offered buffer |
| usb_out_ack | input | 1 | Received packet acknowledged |
| usb_out_len | input | 16 | Byte count of the received packet |
| ep_irq | output | 1 | Receive packet interrupt |

## Verification
Whole transfers are streamed with a packet size of 64. A 512-byte transfer must give eight full packets, and a 510-byte transfer must give seven full packets plus a 62-byte one, which separates commit on packet size from commit on a loaded short length. A 65-byte transfer ends on a single-byte write. A 31-byte transfer at packet size 16 ends in an odd short packet. An 8-byte transfer at packet size 8 has no short packet at all. Directed cases cover a word that straddles the target length, a forced commit, a commit of both buffers followed by stalled writes, and index values that name another endpoint or the control endpoint.

// File: rtl/epbuf_len_pkg.sv
package epbuf_len_pkg;

    typedef enum logic [1:0] {
        ADR_INDEX  = 2'd0,
        ADR_COUNT  = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_MAXPKT = 2'd3
    } reg_adr_e;

    localparam int CTRL_COMMIT_BIT = 0;
    localparam int CTRL_IRQCLR_BIT = 1;

    typedef enum logic [1:0] {
        LANES_LOW  = 2'b01,
        LANES_WORD = 2'b11
    } lanes_e;

endpackage

// File: rtl/epbuf_regs.sv
module epbuf_regs
    import epbuf_len_pkg::*;
#(
    parameter int W       = 16,
    parameter int IDX_W   = 4,
    parameter int EP_NUM  = 2,
    parameter int MPS_DEF = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rst,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         out_ack,
    input  logic [W-1:0] out_len,
    input  logic         commit,
    output logic [W-1:0] short_len,
    output logic [W-1:0] mps,
    output logic         validate,
    output logic         irq
);

    localparam logic [IDX_W-2:0] EP_ID   = EP_NUM[IDX_W-2:0];
    localparam logic [W-1:0]     MPS_RST = MPS_DEF[W-1:0];

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     short_len;
        logic [W-1:0]     out_cnt;
        logic [W-1:0]     mps;
        logic             irq;
    } regs_t;

    localparam regs_t RST_VAL = '{idx: '0, short_len: '0, out_cnt: '0,
                                  mps: MPS_RST, irq: 1'b0};

    regs_t    st_d, st_q;
    reg_adr_e adr;
    logic     sel_in, sel_out, cnt_wr_in;

    always_comb begin
        adr      = reg_adr_e'(reg_addr);
        sel_in   = (st_q.idx[IDX_W-1:1] == EP_ID) &&  st_q.idx[0];
        sel_out  = (st_q.idx[IDX_W-1:1] == EP_ID) && !st_q.idx[0];
        cnt_wr_in = reg_wr && (adr == ADR_COUNT) && sel_in;
        validate = reg_wr && (adr == ADR_CTRL) && sel_in && reg_wdata[CTRL_COMMIT_BIT];

        st_d = st_q;
        if (commit) st_d.short_len = '0;
        if (reg_wr) begin
            unique case (adr)
                ADR_INDEX:  st_d.idx = reg_wdata[IDX_W-1:0];
                ADR_COUNT: begin
                    if (sel_in)       st_d.short_len = reg_wdata;
                    else if (sel_out) st_d.out_cnt   = reg_wdata;
                end
                ADR_CTRL:   if (sel_out && reg_wdata[CTRL_IRQCLR_BIT]) st_d.irq = 1'b0;
                ADR_MAXPKT: if (sel_in && reg_wdata != '0) st_d.mps = reg_wdata;
                default: ;
            endcase
        end
        if (out_ack) begin
            st_d.out_cnt = out_len;
            st_d.irq     = 1'b1;
        end
        if (bus_rst) st_d = RST_VAL;

        reg_rdata = '0;
        unique case (adr)
            ADR_INDEX:  reg_rdata = {{(W-IDX_W){1'b0}}, st_q.idx};
            ADR_COUNT:  reg_rdata = sel_in ? st_q.short_len : (sel_out ? st_q.out_cnt : '0);
            ADR_CTRL:   reg_rdata[CTRL_IRQCLR_BIT] = sel_out & st_q.irq;
            ADR_MAXPKT: reg_rdata = sel_in ? st_q.mps : '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign short_len = st_q.short_len;
    assign mps       = st_q.mps;
    assign irq       = st_q.irq;

    // R10: an acknowledged receive packet always leaves the interrupt raised
    p_irq_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        out_ack |=> irq);

    // R5: a commit without a simultaneous length write clears the short length
    p_len_revert_r5: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        (commit && !cnt_wr_in) |=> (short_len == '0));

endmodule

// File: rtl/epbuf_pingpong.sv
module epbuf_pingpong
    import epbuf_len_pkg::*;
#(
    parameter int W    = 16,
    parameter int NBUF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_rst,
    input  logic         dat_wr,
    input  logic [1:0]   dat_be,
    input  logic [W-1:0] short_len,
    input  logic [W-1:0] mps,
    input  logic         validate,
    input  logic         usb_in_ack,
    output logic         dat_stall,
    output logic         fifo_we,
    output logic [1:0]   fifo_be,
    output logic         tx_valid,
    output logic [W-1:0] tx_len,
    output logic         commit
);

    localparam int PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBUF - 1);

    typedef struct packed {
        logic [W-1:0]            fill;
        logic [PTR_W-1:0]        wr_ptr;
        logic [PTR_W-1:0]        rd_ptr;
        logic [NBUF-1:0]         full;
        logic [NBUF-1:0][W-1:0]  len;
    } pp_t;

    pp_t          st_d, st_q;
    logic [W-1:0] target;
    logic [W:0]   fill_ext, new_fill;
    logic         word_fits, reached, ack_ok;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        target    = ((short_len != '0) && (short_len < mps)) ? short_len : mps;
        dat_stall = st_q.full[st_q.wr_ptr];
        fifo_we   = dat_wr && !dat_stall;
        fill_ext  = {1'b0, st_q.fill};
        word_fits = (dat_be == LANES_WORD) && ((fill_ext + (W+1)'(2)) <= {1'b0, target});
        fifo_be   = word_fits ? LANES_WORD : LANES_LOW;
        new_fill  = fill_ext + (word_fits ? (W+1)'(2) : (W+1)'(1));
        reached   = fifo_we && (new_fill >= {1'b0, target});
        commit    = !dat_stall && (reached || validate);
        ack_ok    = usb_in_ack && st_q.full[st_q.rd_ptr];

        st_d = st_q;
        if (commit) begin
            st_d.full[st_q.wr_ptr] = 1'b1;
            st_d.len[st_q.wr_ptr]  = fifo_we ? new_fill[W-1:0] : st_q.fill;
            st_d.fill              = '0;
            st_d.wr_ptr            = nxt(st_q.wr_ptr);
        end else if (fifo_we) begin
            st_d.fill = new_fill[W-1:0];
        end
        if (ack_ok) begin
            st_d.full[st_q.rd_ptr] = 1'b0;
            st_d.rd_ptr            = nxt(st_q.rd_ptr);
        end
        if (bus_rst) st_d = '0;

        tx_valid = st_q.full[st_q.rd_ptr];
        tx_len   = st_q.len[st_q.rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a refused write leaves the fill count untouched
    p_stall_holds_fill_r9: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        (dat_wr && dat_stall) |=> $stable(st_q.fill));

    // R3: a commit always offers a buffer on the next cycle
    p_commit_offers_r3: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        commit |=> tx_valid);

    // R7: a word trimmed to the low lane always closes the buffer
    p_trim_commits_r7: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        (fifo_we && dat_be == LANES_WORD && fifo_be == LANES_LOW) |-> commit);

    // R12: freeing the offered buffer moves the read side on
    p_ack_advances_r12: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
        (usb_in_ack && tx_valid) |=> (st_q.rd_ptr != $past(st_q.rd_ptr)));

endmodule

// File: rtl/epbuf_len_ctrl.sv
module epbuf_len_ctrl #(
    parameter int W       = 16,
    parameter int IDX_W   = 4,
    parameter int EP_NUM  = 2,
    parameter int MPS_DEF = 64,
    parameter int NBUF    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         usb_bus_rst,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         dat_wr,
    input  logic [1:0]   dat_be,
    output logic         dat_stall,
    output logic         fifo_we,
    output logic [1:0]   fifo_be,
    input  logic         usb_in_ack,
    output logic         tx_valid,
    output logic [W-1:0] tx_len,
    input  logic         usb_out_ack,
    input  logic [W-1:0] usb_out_len,
    output logic         ep_irq
);

    logic [W-1:0] short_len, mps;
    logic         validate, commit;

    epbuf_regs #(.W(W), .IDX_W(IDX_W), .EP_NUM(EP_NUM), .MPS_DEF(MPS_DEF)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (usb_bus_rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .out_ack   (usb_out_ack),
        .out_len   (usb_out_len),
        .commit    (commit),
        .short_len (short_len),
        .mps       (mps),
        .validate  (validate),
        .irq       (ep_irq)
    );

    epbuf_pingpong #(.W(W), .NBUF(NBUF)) u_pp (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (usb_bus_rst),
        .dat_wr     (dat_wr),
        .dat_be     (dat_be),
        .short_len  (short_len),
        .mps        (mps),
        .validate   (validate),
        .usb_in_ack (usb_in_ack),
        .dat_stall  (dat_stall),
        .fifo_we    (fifo_we),
        .fifo_be    (fifo_be),
        .tx_valid   (tx_valid),
        .tx_len     (tx_len),
        .commit     (commit)
    );

endmodule

// File: tb/epbuf_len_ctrl_tb.sv
module epbuf_len_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, usb_bus_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        dat_wr = 1'b0;
    logic [1:0]  dat_be = 2'b11;
    logic        dat_stall, fifo_we;
    logic [1:0]  fifo_be;
    logic        usb_in_ack = 1'b0, tx_valid;
    logic [15:0] tx_len;
    logic        usb_out_ack = 1'b0;
    logic [15:0] usb_out_len = '0;
    logic        ep_irq;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [1:0] last_be;
    logic       last_we;
    logic [15:0] rd;

    // {packet size, total bytes, expected packets, expected last length}
    localparam int unsigned VEC [5][4] = '{
        '{64, 512, 8, 64},
        '{64, 510, 8, 62},
        '{64,  65, 2,  1},
        '{16,  31, 2, 15},
        '{ 8,   8, 1,  8}
    };

    always #2 clk = ~clk;

    epbuf_len_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .usb_bus_rst(usb_bus_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_be(dat_be), .dat_stall(dat_stall),
        .fifo_we(fifo_we), .fifo_be(fifo_be),
        .usb_in_ack(usb_in_ack), .tx_valid(tx_valid), .tx_len(tx_len),
        .usb_out_ack(usb_out_ack), .usb_out_len(usb_out_len), .ep_irq(ep_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic data_write(input logic [1:0] be);
        @(negedge clk);
        dat_wr = 1'b1; dat_be = be;
        #1;
        last_be = fifo_be; last_we = fifo_we;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic in_ack();
        @(negedge clk);
        usb_in_ack = 1'b1;
        @(negedge clk);
        usb_in_ack = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, rd); chk(rd == 0, "R1 index", rd, 0);
        chk(!tx_valid && !ep_irq && !dat_stall, "R1 outputs", {tx_valid, ep_irq, dat_stall}, 0);
        reg_write(2'd0, 16'd5);
        reg_read(2'd1, rd); chk(rd == 0, "R1 count", rd, 0);
        reg_read(2'd3, rd); chk(rd == 64, "R1 packet size", rd, 64);

        // R2 index decode: control endpoint and other endpoints do not match
        reg_write(2'd0, 16'd1);
        reg_write(2'd1, 16'd5);
        reg_read(2'd1, rd); chk(rd == 0, "R2 control ep read", rd, 0);
        reg_write(2'd0, 16'd5);
        reg_read(2'd1, rd); chk(rd == 0, "R2 write ignored", rd, 0);
        reg_write(2'd0, 16'd3);
        reg_read(2'd3, rd); chk(rd == 0, "R2 other ep", rd, 0);

        // R11 transmit count readback
        reg_write(2'd0, 16'd5);
        reg_write(2'd1, 16'd10);
        reg_read(2'd1, rd); chk(rd == 10, "R11 in count", rd, 10);
        reg_write(2'd1, 16'd0);

        // R4 R7 R5: short length 3 with a straddling word
        reg_write(2'd1, 16'd3);
        data_write(2'b11); chk(last_be == 2'b11, "R7 full word", last_be, 3);
        data_write(2'b11); chk(last_be == 2'b01 && last_we, "R7 trimmed word", last_be, 1);
        #1;
        chk(tx_valid && tx_len == 3, "R4 short commit", tx_len, 3);
        reg_read(2'd1, rd); chk(rd == 0, "R5 revert", rd, 0);
        in_ack();
        #1; chk(!tx_valid, "R12 freed", tx_valid, 0);

        // R3 commit at packet size 4
        reg_write(2'd3, 16'd4);
        data_write(2'b11); data_write(2'b11);
        #1; chk(tx_valid && tx_len == 4, "R3 full commit", tx_len, 4);
        in_ack();

        // R6 forced commit
        data_write(2'b11);
        reg_write(2'd2, 16'd1);
        #1; chk(tx_valid && tx_len == 2, "R6 forced commit", tx_len, 2);
        in_ack();

        // R8 R9 both buffers committed
        data_write(2'b11); data_write(2'b11);
        data_write(2'b11); data_write(2'b11);
        #1; chk(dat_stall, "R9 stall", dat_stall, 1);
        data_write(2'b11); chk(!last_we, "R9 write refused", last_we, 0);
        reg_write(2'd2, 16'd1);
        #1; chk(tx_valid && tx_len == 4, "R8 first buffer", tx_len, 4);
        in_ack();
        #1; chk(tx_valid && tx_len == 4 && !dat_stall, "R8 second buffer", tx_len, 4);
        data_write(2'b11);
        reg_write(2'd2, 16'd1);
        in_ack();
        #1; chk(tx_valid && tx_len == 2, "R9 refused write not counted", tx_len, 2);
        in_ack();
        #1; chk(!tx_valid, "R12 drained", tx_valid, 0);

        // R10 receive side
        reg_write(2'd0, 16'd4);
        @(negedge clk); usb_out_ack = 1'b1; usb_out_len = 16'd37;
        @(negedge clk); usb_out_ack = 1'b0;
        #1; chk(ep_irq, "R10 irq set", ep_irq, 1);
        reg_read(2'd1, rd); chk(rd == 37, "R10 out count", rd, 37);
        reg_read(2'd2, rd); chk(rd[1], "R10 irq readback", rd, 2);
        reg_write(2'd2, 16'd2);
        #1; chk(!ep_irq, "R10 irq clear", ep_irq, 0);
        reg_write(2'd1, 16'd9);
        reg_read(2'd1, rd); chk(rd == 9, "R11 out count", rd, 9);

        // R1 bus reset
        reg_write(2'd0, 16'd5);
        reg_write(2'd1, 16'd7);
        data_write(2'b11);
        @(negedge clk); usb_bus_rst = 1'b1;
        @(negedge clk); usb_bus_rst = 1'b0;
        reg_read(2'd0, rd); chk(rd == 0, "R1 bus reset index", rd, 0);
        reg_write(2'd0, 16'd5);
        reg_read(2'd1, rd); chk(rd == 0, "R1 bus reset count", rd, 0);
        reg_read(2'd3, rd); chk(rd == 64, "R1 bus reset size", rd, 64);
        reg_write(2'd2, 16'd1);
        #1; chk(tx_valid && tx_len == 0, "R1 fill cleared", tx_len, 0);
        in_ack();

        // R3 R4 R8: whole transfers from the vector table
        for (int v = 0; v < 5; v++) begin
            int mps_v, total, full_part, written, pk, lastlen, nonfull, settle;
            bit need_len;
            mps_v = int'(VEC[v][0]); total = int'(VEC[v][1]);
            reg_write(2'd3, 16'(mps_v));
            full_part = total - (total % mps_v);
            need_len = (total % mps_v) != 0;
            written = 0; pk = 0; lastlen = 0; nonfull = 0; settle = 0;
            for (int cyc = 0; cyc < 4000 && settle < 3; cyc++) begin
                @(negedge clk); #1;
                usb_in_ack = tx_valid;
                if (tx_valid) begin
                    pk++; lastlen = int'(tx_len);
                    if (int'(tx_len) != mps_v) nonfull++;
                end
                reg_wr = 1'b0; dat_wr = 1'b0;
                if (written < total) begin
                    if (need_len && written == full_part) begin
                        reg_wr = 1'b1; reg_addr = 2'd1;
                        reg_wdata = 16'(total - full_part);
                        need_len = 0;
                    end else if (!dat_stall) begin
                        dat_wr = 1'b1;
                        dat_be = (total - written >= 2) ? 2'b11 : 2'b01;
                        written += (total - written >= 2) ? 2 : 1;
                    end
                end else if (!tx_valid) begin
                    settle++;
                end
            end
            @(negedge clk);
            usb_in_ack = 1'b0; reg_wr = 1'b0; dat_wr = 1'b0;
            chk(pk == int'(VEC[v][2]), "R3 R4 packet count", pk, int'(VEC[v][2]));
            chk(lastlen == int'(VEC[v][3]), "R4 last length", lastlen, int'(VEC[v][3]));
            chk(nonfull == ((total % mps_v) != 0 ? 1 : 0), "R8 full packets", nonfull,
                (total % mps_v) != 0 ? 1 : 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule